// File: doc/BRIEF.md
# Preemptible Control-Flow Edge Table Walker

This block decides whether one control-flow edge, given as a source address and a target address, is legal. It searches a table of known-good edges held in a small on-chip memory with a synchronous read port. Each table record carries a valid bit, a source address and a target address. In the intended layout a record takes 16 bytes, and the default table of 256 records stays under 5 KB. The walk starts at record 0 and moves upward. It stops early on the first record whose valid bit is set and whose two addresses both equal the edge under test. If it reaches the last record with no hit, the edge is reported illegal and a halt request is raised.

The search is made of indivisible steps. A step issues one table read and compares the returned record in the following cycle. A scheduler grants cycles through `run_i`. When the grant drops, the walker finishes any step already in flight and then parks. It keeps the edge and the current record index in its own registers, so a later grant resumes the walk exactly where it stopped. While a walk is running or parked, a new start request is refused.

Top module: `edge_table_walker`

## Requirements
- R1: A step reads record k in one cycle (`tbl_rd_en_o`=1, `tbl_rd_idx_o`=k) and compares it in the next cycle. A walk reads indices 0, 1, 2, ... in order, one apart, and with `run_i` held high it issues one read per cycle.
- R2: A read is issued only in a cycle where `run_i`=1. A read already issued is always compared in the next cycle, even if `run_i` has dropped.
- R3: A record matches when its valid bit is 1, its source equals the entry source and its target equals the entry target. When record m matches, `done_o` and `legal_o` are 1 for exactly one cycle, starting two cycles after record m was read, and no further record is read (m+1 reads in total).
- R4: While `run_i`=0 the walk parks. When the grant returns, reading continues at the next unread index, and the entry under test is unchanged.
- R5: If record DEPTH-1 is compared without a match, `done_o` pulses with `legal_o`=0 and `halt_o`=1 in that same cycle, after DEPTH reads. `halt_o` is never 1 without `done_o`.
- R6: `start_accept_o`=1 exactly when `start_i`=1 and no walk is running or parked. A refused start does not change the entry under test.
- R7: `busy_o` is 1 from the cycle after an accepted start until the cycle in which `done_o` pulses; in that cycle it is 0.
- R8: During and right after reset, `busy_o`, `done_o`, `halt_o` and `tbl_rd_en_o` are 0.
- R9: A record whose valid bit is 0 never matches, even when both of its addresses equal the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Request to validate a new edge |
| start_src_i | input | ADDR_W | Source address of the edge |
| start_dst_i | input | ADDR_W | Target address of the edge |
| run_i | input | 1 | Cycle grant from the scheduler; low means park after the current step |
| start_accept_o | output | 1 | Start taken this cycle |
| busy_o | output | 1 | A walk is running or parked |
| done_o | output | 1 | One-cycle result pulse |
| legal_o | output | 1 | Result with done_o: 1 legal, 0 illegal |
| halt_o | output | 1 | Halt request, pulsed with an illegal result |
| tbl_rd_en_o | output | 1 | Table read strobe |
| tbl_rd_idx_o | output | IDX_W | Record index to read |
| tbl_rd_valid_i | input | 1 | Valid bit of the record read in the previous cycle |
| tbl_rd_src_i | input | ADDR_W | Source address of that record |
| tbl_rd_dst_i | input | ADDR_W | Target address of that record |

## Verification
The assertions assume the table port returns the requested record exactly one cycle after the read strobe and holds it stable for the compare. They also assume that `start_i` and `run_i` change only away from the clock edge. The bench meets this with a behavioural memory that latches each request and presents its data on the following edge, and it drives every input one time unit after the rising edge. Grant patterns come from a shift-register sequence, so parking and resuming happen at both the issue point and the compare point. While parked, the bench tries a start carrying an edge that would match early, to show that it is refused.

// File: rtl/etw_pkg.sv
package etw_pkg;
  typedef enum logic [1:0] {
    ETW_IDLE  = 2'd0,
    ETW_READY = 2'd1,
    ETW_CMP   = 2'd2
  } etw_state_e;
endpackage

// File: rtl/etw_rst_sync.sv
module etw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/etw_hold_reg.sv
module etw_hold_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/etw_index_ctr.sv
module etw_index_ctr #(
  parameter int DEPTH = 256,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [IDX_W-1:0] idx_q,
  output logic [IDX_W-1:0] idx_d,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  always_comb begin
    if (clr)      idx_d = '0;
    else if (inc) idx_d = idx_q + 1'b1;
    else          idx_d = idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idx_q <= '0;
    else if (clr || inc) idx_q <= idx_d;
  end

  assign last = (idx_q == LAST_IDX);
endmodule

// File: rtl/etw_match.sv
module etw_match #(
  parameter int ADDR_W = 32
) (
  input  logic              rec_valid,
  input  logic [ADDR_W-1:0] rec_src,
  input  logic [ADDR_W-1:0] rec_dst,
  input  logic [ADDR_W-1:0] ent_src,
  input  logic [ADDR_W-1:0] ent_dst,
  output logic              hit
);
  logic src_eq;
  logic dst_eq;

  always_comb begin
    src_eq = (rec_src == ent_src);
    dst_eq = (rec_dst == ent_dst);
    hit    = rec_valid && src_eq && dst_eq;
  end
endmodule

// File: rtl/etw_ctrl.sv
module etw_ctrl
  import etw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  input  logic hit_i,
  input  logic last_i,
  output logic accept_o,
  output logic load_o,
  output logic clr_o,
  output logic inc_o,
  output logic rd_en_o,
  output logic busy_o,
  output logic done_o,
  output logic legal_o,
  output logic halt_o
);
  etw_state_e state_q, state_d;
  logic       fin;
  logic       done_q, legal_q, halt_q;

  always_comb begin
    state_d  = state_q;
    accept_o = 1'b0;
    load_o   = 1'b0;
    clr_o    = 1'b0;
    inc_o    = 1'b0;
    rd_en_o  = 1'b0;
    fin      = 1'b0;
    case (state_q)
      ETW_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          load_o   = 1'b1;
          clr_o    = 1'b1;
          state_d  = ETW_READY;
        end
      end
      ETW_READY: begin
        if (run_i) begin
          rd_en_o = 1'b1;
          state_d = ETW_CMP;
        end
      end
      ETW_CMP: begin
        if (hit_i || last_i) begin
          fin     = 1'b1;
          state_d = ETW_IDLE;
        end else begin
          inc_o = 1'b1;
          if (run_i) begin
            rd_en_o = 1'b1;
            state_d = ETW_CMP;
          end else begin
            state_d = ETW_READY;
          end
        end
      end
      default: state_d = ETW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ETW_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      legal_q <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      done_q  <= fin;
      legal_q <= fin && hit_i;
      halt_q  <= fin && !hit_i;
    end
  end

  assign busy_o  = (state_q != ETW_IDLE);
  assign done_o  = done_q;
  assign legal_o = legal_q;
  assign halt_o  = halt_q;
endmodule

// File: rtl/edge_table_walker.sv
module edge_table_walker #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 256,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_src_i,
  input  logic [ADDR_W-1:0] start_dst_i,
  input  logic              run_i,
  output logic              start_accept_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              legal_o,
  output logic              halt_o,
  output logic              tbl_rd_en_o,
  output logic [IDX_W-1:0]  tbl_rd_idx_o,
  input  logic              tbl_rd_valid_i,
  input  logic [ADDR_W-1:0] tbl_rd_src_i,
  input  logic [ADDR_W-1:0] tbl_rd_dst_i
);
  logic              rst_n_int;
  logic              load, clr, inc, hit, last;
  logic [ADDR_W-1:0] ent_src, ent_dst;
  logic [IDX_W-1:0]  idx_q, idx_d;

  etw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  etw_hold_reg #(.WIDTH(ADDR_W)) u_ent_src (
    .clk (clk), .rst_n (rst_n_int), .load (load), .d (start_src_i), .q (ent_src)
  );

  etw_hold_reg #(.WIDTH(ADDR_W)) u_ent_dst (
    .clk (clk), .rst_n (rst_n_int), .load (load), .d (start_dst_i), .q (ent_dst)
  );

  etw_index_ctr #(.DEPTH(DEPTH)) u_idx (
    .clk   (clk),
    .rst_n (rst_n_int),
    .clr   (clr),
    .inc   (inc),
    .idx_q (idx_q),
    .idx_d (idx_d),
    .last  (last)
  );

  etw_match #(.ADDR_W(ADDR_W)) u_match (
    .rec_valid (tbl_rd_valid_i),
    .rec_src   (tbl_rd_src_i),
    .rec_dst   (tbl_rd_dst_i),
    .ent_src   (ent_src),
    .ent_dst   (ent_dst),
    .hit       (hit)
  );

  etw_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start_i  (start_i),
    .run_i    (run_i),
    .hit_i    (hit),
    .last_i   (last),
    .accept_o (start_accept_o),
    .load_o   (load),
    .clr_o    (clr),
    .inc_o    (inc),
    .rd_en_o  (tbl_rd_en_o),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .legal_o  (legal_o),
    .halt_o   (halt_o)
  );

  assign tbl_rd_idx_o = idx_d;
endmodule

// File: rtl/etw_chk.sv
module etw_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             run_i,
  input logic             start_accept_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             legal_o,
  input logic             halt_o,
  input logic             tbl_rd_en_o,
  input logic [IDX_W-1:0] tbl_rd_idx_o
);
  assert_read_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_rd_en_o && $past(tbl_rd_en_o)) |-> (tbl_rd_idx_o == IDX_W'($past(tbl_rd_idx_o) + 1'b1)));

  assert_read_needs_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_en_o |-> run_i);

  assert_step_completes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_en_o |=> busy_o);

  assert_result_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(tbl_rd_en_o, 2));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_halt_with_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> (done_o && !legal_o));

  assert_accept_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept_o |-> (start_i && !busy_o));

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept_o |=> busy_o);

  assert_not_busy_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_read_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_en_o |-> busy_o);
endmodule

bind edge_table_walker etw_chk #(.IDX_W(IDX_W)) u_etw_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start_i        (start_i),
  .run_i          (run_i),
  .start_accept_o (start_accept_o),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .legal_o        (legal_o),
  .halt_o         (halt_o),
  .tbl_rd_en_o    (tbl_rd_en_o),
  .tbl_rd_idx_o   (tbl_rd_idx_o)
);

// File: tb/tb_edge_table_walker.sv
module tb_edge_table_walker;
  localparam int AW    = 32;
  localparam int DEPTH = 256;
  localparam int IW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] start_src_i = '0;
  logic [AW-1:0] start_dst_i = '0;
  logic          run_i = 1'b0;
  logic          start_accept_o, busy_o, done_o, legal_o, halt_o, tbl_rd_en_o;
  logic [IW-1:0] tbl_rd_idx_o;
  logic          tbl_rd_valid_i = 1'b0;
  logic [AW-1:0] tbl_rd_src_i = '0;
  logic [AW-1:0] tbl_rd_dst_i = '0;

  always #5 clk = ~clk;

  edge_table_walker dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_src_i(start_src_i),
    .start_dst_i(start_dst_i), .run_i(run_i), .start_accept_o(start_accept_o),
    .busy_o(busy_o), .done_o(done_o), .legal_o(legal_o), .halt_o(halt_o),
    .tbl_rd_en_o(tbl_rd_en_o), .tbl_rd_idx_o(tbl_rd_idx_o),
    .tbl_rd_valid_i(tbl_rd_valid_i), .tbl_rd_src_i(tbl_rd_src_i),
    .tbl_rd_dst_i(tbl_rd_dst_i)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // golden table contents
  logic          g_v [DEPTH];
  logic [AW-1:0] g_s [DEPTH];
  logic [AW-1:0] g_d [DEPTH];

  function automatic logic [AW-1:0] src_of(input int i);
    return 32'h1000_0000 + AW'(i) * 32'd16;
  endfunction
  function automatic logic [AW-1:0] dst_of(input int i);
    return 32'h2000_0000 + AW'(i) * 32'd4;
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      g_v[i] = 1'b1; g_s[i] = src_of(i); g_d[i] = dst_of(i);
    end
    g_v[5] = 1'b0; g_s[5] = src_of(9); g_d[5] = dst_of(9);
  end

  // synchronous-read memory: request latched away from the edge
  logic          req_en;
  int            req_idx;
  int            rd_count = 0;
  int            rd_no_grant = 0;
  always @(negedge clk) begin
    req_en  = tbl_rd_en_o;
    req_idx = int'(tbl_rd_idx_o);
    if (tbl_rd_en_o) rd_count++;
    if (tbl_rd_en_o && !run_i) rd_no_grant++;
  end
  always @(posedge clk) begin
    if (req_en) begin
      tbl_rd_valid_i <= g_v[req_idx];
      tbl_rd_src_i   <= g_s[req_idx];
      tbl_rd_dst_i   <= g_d[req_idx];
    end
  end

  // behavioural reference model
  int            m_state = 0;
  int            m_idx = 0;
  logic [AW-1:0] m_src = '0, m_dst = '0;
  bit            m_done = 0, m_legal = 0, m_halt = 0;
  bit [1:0]      m_sync = 2'b00;

  function automatic bit m_hit(input int i);
    return g_v[i] && g_s[i] == m_src && g_d[i] == m_dst;
  endfunction

  always @(posedge clk) begin
    bit act;
    act = m_sync[1];
    m_sync = rst_n ? {m_sync[0], 1'b1} : 2'b00;
    if (!rst_n || !act) begin
      m_state = 0; m_idx = 0; m_done = 0; m_legal = 0; m_halt = 0;
    end else begin
      m_done = 0; m_legal = 0; m_halt = 0;
      case (m_state)
        0: if (start_i) begin
             m_src = start_src_i; m_dst = start_dst_i; m_idx = 0; m_state = 1;
           end
        1: if (run_i) m_state = 2;
        default: begin
          if (m_hit(m_idx)) begin
            m_done = 1; m_legal = 1; m_state = 0;
          end else if (m_idx == DEPTH - 1) begin
            m_done = 1; m_halt = 1; m_state = 0;
          end else begin
            m_idx++;
            m_state = run_i ? 2 : 1;
          end
        end
      endcase
    end
  end

  // per-cycle comparison against the model
  bit model_on = 0;
  always @(negedge clk) begin
    if (model_on) begin
      bit fin, e_rd;
      int e_idx;
      fin   = (m_state == 2) && (m_hit(m_idx) || m_idx == DEPTH - 1);
      e_rd  = run_i && (m_state == 1 || (m_state == 2 && !fin));
      e_idx = (m_state == 1) ? m_idx : m_idx + 1;
      check(busy_o == (m_state != 0), "R7 busy", busy_o, m_state != 0);
      check(start_accept_o == (start_i && m_state == 0), "R6 accept",
            start_accept_o, start_i && m_state == 0);
      check(tbl_rd_en_o == e_rd, "R1/R2 read strobe", tbl_rd_en_o, e_rd);
      if (e_rd) check(int'(tbl_rd_idx_o) == e_idx, "R1/R4 read index", tbl_rd_idx_o, e_idx);
      check(done_o == m_done, "R3 done", done_o, m_done);
      check(legal_o == m_legal, "R3 legal", legal_o, m_legal);
      check(halt_o == m_halt, "R5 halt", halt_o, m_halt);
    end
  end

  logic [15:0] lfsr = 16'hACE1;
  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // mode 0: grant always high; mode 1: pseudo-random grant plus refused starts
  task automatic walk(input logic [AW-1:0] s, input logic [AW-1:0] d, input int mode,
                      input bit exp_legal, input int exp_reads, input string tag);
    int  cyc;
    bit  seen;
    int  tries;
    @(posedge clk); #1;
    rd_count = 0;
    start_i = 1'b1; start_src_i = s; start_dst_i = d;
    run_i = (mode == 0);
    @(negedge clk);
    check(start_accept_o == 1'b1, {tag, " R6 start taken"}, start_accept_o, 1);
    seen = 0; cyc = 0; tries = 0;
    while (!seen && cyc < 2000) begin
      @(posedge clk); #1;
      start_i = 1'b0;
      if (mode == 0) run_i = 1'b1;
      else begin
        step_lfsr();
        run_i = lfsr[0] | lfsr[3];
        if (!run_i && busy_o && tries < 4) begin
          start_i = 1'b1; start_src_i = src_of(2); start_dst_i = dst_of(2);
          tries++;
        end
      end
      @(negedge clk);
      if (start_i) check(start_accept_o == 1'b0, {tag, " R6 refused while parked"}, start_accept_o, 0);
      cyc++;
      if (done_o) seen = 1;
    end
    if (!seen) check(1'b0, {tag, " watchdog"}, cyc, 2000);
    check(legal_o == exp_legal, {tag, " R3/R5 result"}, legal_o, exp_legal);
    check(halt_o == !exp_legal, {tag, " R5 halt"}, halt_o, !exp_legal);
    check(busy_o == 1'b0, {tag, " R7 busy low at done"}, busy_o, 0);
    check(rd_count == exp_reads, {tag, " R3/R4 read count"}, rd_count, exp_reads);
    @(posedge clk); #1;
    start_i = 1'b0; run_i = 1'b0;
    @(negedge clk);
    check(done_o == 1'b0, {tag, " R3 done is one pulse"}, done_o, 0);
  endtask

  initial begin
    bit timed_out;
    timed_out = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        model_on = 1;
        check(!busy_o && !done_o && !halt_o && !tbl_rd_en_o, "R8 reset outputs",
              {busy_o, done_o, halt_o, tbl_rd_en_o}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!busy_o && !done_o && !tbl_rd_en_o, "R8 after release",
              {busy_o, done_o, tbl_rd_en_o}, 0);

        walk(src_of(3),   dst_of(3),   0, 1'b1, 4,     "R3 hit at 3");
        walk(src_of(0),   dst_of(0),   0, 1'b1, 1,     "R3 hit at 0");
        walk(src_of(9),   dst_of(9),   0, 1'b1, 10,    "R9 invalid record skipped");
        walk(src_of(3),   dst_of(4),   0, 1'b0, DEPTH, "R5 half match");
        walk(src_of(40),  dst_of(40),  1, 1'b1, 41,    "R4 parked walk");
        walk(src_of(255), dst_of(255), 0, 1'b1, DEPTH, "R1 hit at last");
        walk(src_of(5),   dst_of(5),   1, 1'b0, DEPTH, "R5 R9 parked miss");
        check(rd_no_grant == 0, "R2 reads only with grant", rd_no_grant, 0);
      end
      begin
        #1000000;
        timed_out = 1;
      end
    join_any
    if (timed_out) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule